// File: doc/BRIEF.md
# Pin-Interrupt GPIO Port

This block is an eight-pin general purpose I/O port with a small register interface. Software can drive each pin from a stored output value and an output-enable (direction) bit. It can read back either that stored value or the live pin level. Each pin can also raise an interrupt on a rising or a falling edge, chosen per pin. Edge events are latched in a flag register that software clears by writing ones. One interrupt line goes high while any latched flag has its enable bit set.

The same eight pins are shared with three peripherals, each seen here only as an enable plus per-pin output value and output-enable. The first SPI channel sits on pins 3..0. The second SPI channel sits on pins 7..4. A serial port uses pins 7 and 6. When a peripheral is enabled it takes the pin from GPIO in a fixed priority order. Pin inputs always pass through a synchroniser, so edge flags keep working on a pin that a peripheral owns.

Register access uses a single-cycle bus: address, write strobe and write data are sampled on the clock edge, and read data is combinational from the address.

Top module: `pinport_ctrl`

## Requirements
- R1: After synchronous reset every register (addresses 0 to 4) reads 0, `irq` is 0 and, with no peripheral enabled, every `pin_oe` bit is 0.
- R2: A pin whose polarity bit (address 2) is 1 sets its flag bit (address 4) on a rising edge of its synchronised input, and one whose polarity bit is 0 does so on a falling edge; the other edge direction leaves the flag clear. The flag is readable three clock edges after the pin changes.
- R3: Writing address 4 with a 1 in a bit position clears that flag bit.
- R4: Writing a 0 to a flag bit leaves it unchanged. If a new active edge and a clearing write hit the same bit in the same cycle, the flag stays 1.
- R5: `irq` is 1 exactly when some bit is 1 in both the flag register and the enable register (address 3).
- R6: Reading address 0 returns, per bit, the stored data bit where the direction bit (address 1) is 1 and the synchronised pin level where it is 0.
- R7: A pin owned by GPIO drives `pin_out` from its data bit and `pin_oe` from its direction bit.
- R8: When `spi_b_en` is 1, pins 7..4 take `pin_out`/`pin_oe` from `spi_b_out[3:0]`/`spi_b_oe[3:0]` (bit n drives pin n+4), whatever the serial port's enable.
- R9: When `uart_en` is 1 and `spi_b_en` is 0, pins 7 and 6 take their drive from `uart_out[1]`/`uart_out[0]` and `uart_oe[1]`/`uart_oe[0]`; pins 5 and 4 stay with GPIO.
- R10: When `spi_a_en` is 1, pins 3..0 take their drive from `spi_a_out[3:0]`/`spi_a_oe[3:0]` (bit n drives pin n).
- R11: Edge detection and flag setting on a pin continue while a peripheral owns it.
- R12: Addresses 1, 2 and 3 read back the last value written. Addresses 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Combined pin interrupt |
| spi_a_en | input | 1 | First SPI channel enable (pins 3..0) |
| spi_a_out | input | 4 | First SPI channel output values |
| spi_a_oe | input | 4 | First SPI channel output enables |
| spi_b_en | input | 1 | Second SPI channel enable (pins 7..4) |
| spi_b_out | input | 4 | Second SPI channel output values |
| spi_b_oe | input | 4 | Second SPI channel output enables |
| uart_en | input | 1 | Serial port enable (pins 7..6) |
| uart_out | input | 2 | Serial port output values |
| uart_oe | input | 2 | Serial port output enables |

## Verification
The bench builds the block with its default two-stage synchroniser, which fixes the pin-to-flag latency at three edges. That fixed latency lets the bench time a clearing write to land in the same cycle as a fresh edge detection. Random enable combinations across all three peripherals reach every branch of the ownership chain, including the case where the serial port is enabled but overridden. Random direction masks against random pin levels exercise mixed read-back on the data register.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

    localparam int PORT_W = 8;
    localparam int SPI_W  = 4;
    localparam int UART_W = 2;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_POL  = 3'd2,
        REG_IEN  = 3'd3,
        REG_FLAG = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        OWN_GPIO,
        OWN_UART,
        OWN_SPI_A,
        OWN_SPI_B
    } owner_e;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] pol;
        logic [PORT_W-1:0] ien;
        logic [PORT_W-1:0] flag;
    } port_regs_t;

    // Fixed priority: second SPI > serial port > GPIO on the upper half,
    // first SPI > GPIO on the lower half.
    function automatic owner_e pin_owner(input int idx, input logic a_en,
                                         input logic b_en, input logic u_en);
        if (idx >= SPI_W) begin
            if (b_en) return OWN_SPI_B;
            if (idx >= PORT_W - UART_W && u_en) return OWN_UART;
            return OWN_GPIO;
        end
        if (a_en) return OWN_SPI_A;
        return OWN_GPIO;
    endfunction

endpackage

// File: rtl/pinport_sync.sv
module pinport_sync
    import pinport_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] pol,
    output logic [PORT_W-1:0] sync,
    output logic [PORT_W-1:0] act_edge
);
    logic [PORT_W-1:0] chain [STAGES];
    logic [PORT_W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
            prev <= '0;
        end else begin
            chain[0] <= pin_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            prev <= chain[STAGES-1];
        end
    end

    assign sync = chain[STAGES-1];

    logic [PORT_W-1:0] rise, fall;
    assign rise     = sync & ~prev;
    assign fall     = ~sync & prev;
    assign act_edge = (pol & rise) | (~pol & fall);
endmodule

// File: rtl/pinport_regs.sv
module pinport_regs
    import pinport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic [PORT_W-1:0] sync,
    input  logic [PORT_W-1:0] act_edge,
    output port_regs_t        regs,
    output logic [PORT_W-1:0] bus_rdata
);
    reg_addr_e         sel;
    logic [PORT_W-1:0] clr_mask;

    assign sel      = reg_addr_e'(bus_addr);
    assign clr_mask = (bus_we && sel == REG_FLAG) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (bus_we) begin
                case (sel)
                    REG_DATA: regs.data <= bus_wdata;
                    REG_DIR:  regs.dir  <= bus_wdata;
                    REG_POL:  regs.pol  <= bus_wdata;
                    REG_IEN:  regs.ien  <= bus_wdata;
                    default:  ;
                endcase
            end
            // a fresh edge wins over a same-cycle clear
            regs.flag <= (regs.flag & ~clr_mask) | act_edge;
        end
    end

    always_comb begin
        case (sel)
            REG_DATA: bus_rdata = (regs.data & regs.dir) | (sync & ~regs.dir);
            REG_DIR:  bus_rdata = regs.dir;
            REG_POL:  bus_rdata = regs.pol;
            REG_IEN:  bus_rdata = regs.ien;
            REG_FLAG: bus_rdata = regs.flag;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pinport_mux.sv
module pinport_mux
    import pinport_pkg::*;
(
    input  logic              spi_a_en,
    input  logic [SPI_W-1:0]  spi_a_out,
    input  logic [SPI_W-1:0]  spi_a_oe,
    input  logic              spi_b_en,
    input  logic [SPI_W-1:0]  spi_b_out,
    input  logic [SPI_W-1:0]  spi_b_oe,
    input  logic              uart_en,
    input  logic [UART_W-1:0] uart_out,
    input  logic [UART_W-1:0] uart_oe,
    input  logic [PORT_W-1:0] gpio_out,
    input  logic [PORT_W-1:0] gpio_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        owner_e own;
        assign own = pin_owner(i, spi_a_en, spi_b_en, uart_en);

        if (i >= PORT_W - UART_W) begin : g_top
            always_comb begin
                case (own)
                    OWN_SPI_B: begin pin_out[i] = spi_b_out[i-SPI_W];
                                     pin_oe[i]  = spi_b_oe[i-SPI_W]; end
                    OWN_UART:  begin pin_out[i] = uart_out[i-(PORT_W-UART_W)];
                                     pin_oe[i]  = uart_oe[i-(PORT_W-UART_W)]; end
                    default:   begin pin_out[i] = gpio_out[i];
                                     pin_oe[i]  = gpio_oe[i]; end
                endcase
            end
        end else if (i >= SPI_W) begin : g_mid
            always_comb begin
                if (own == OWN_SPI_B) begin
                    pin_out[i] = spi_b_out[i-SPI_W];
                    pin_oe[i]  = spi_b_oe[i-SPI_W];
                end else begin
                    pin_out[i] = gpio_out[i];
                    pin_oe[i]  = gpio_oe[i];
                end
            end
        end else begin : g_low
            always_comb begin
                if (own == OWN_SPI_A) begin
                    pin_out[i] = spi_a_out[i];
                    pin_oe[i]  = spi_a_oe[i];
                end else begin
                    pin_out[i] = gpio_out[i];
                    pin_oe[i]  = gpio_oe[i];
                end
            end
        end
    end
endmodule

// File: rtl/pinport_ctrl.sv
module pinport_ctrl
    import pinport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic              irq,
    input  logic              spi_a_en,
    input  logic [SPI_W-1:0]  spi_a_out,
    input  logic [SPI_W-1:0]  spi_a_oe,
    input  logic              spi_b_en,
    input  logic [SPI_W-1:0]  spi_b_out,
    input  logic [SPI_W-1:0]  spi_b_oe,
    input  logic              uart_en,
    input  logic [UART_W-1:0] uart_out,
    input  logic [UART_W-1:0] uart_oe
);
    port_regs_t        regs;
    logic [PORT_W-1:0] sync;
    logic [PORT_W-1:0] act_edge;

    pinport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .pol      (regs.pol),
        .sync     (sync),
        .act_edge (act_edge)
    );

    pinport_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .sync      (sync),
        .act_edge  (act_edge),
        .regs      (regs),
        .bus_rdata (bus_rdata)
    );

    pinport_mux u_mux (
        .spi_a_en  (spi_a_en),
        .spi_a_out (spi_a_out),
        .spi_a_oe  (spi_a_oe),
        .spi_b_en  (spi_b_en),
        .spi_b_out (spi_b_out),
        .spi_b_oe  (spi_b_oe),
        .uart_en   (uart_en),
        .uart_out  (uart_out),
        .uart_oe   (uart_oe),
        .gpio_out  (regs.data),
        .gpio_oe   (regs.dir),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    assign irq = |(regs.flag & regs.ien);
endmodule

// File: rtl/pinport_checker.sv
module pinport_checker
    import pinport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] flag_q,
    input logic [PORT_W-1:0] ien_q,
    input logic [PORT_W-1:0] act_edge,
    input logic              irq,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_oe,
    input logic              spi_a_en,
    input logic [SPI_W-1:0]  spi_a_out,
    input logic [SPI_W-1:0]  spi_a_oe,
    input logic              spi_b_en,
    input logic [SPI_W-1:0]  spi_b_out,
    input logic [SPI_W-1:0]  spi_b_oe,
    input logic              uart_en,
    input logic [UART_W-1:0] uart_out,
    input logic [UART_W-1:0] uart_oe
);
    logic              flag_wr;
    logic [PORT_W-1:0] clr_req;
    assign flag_wr = bus_we && (bus_addr == REG_FLAG);
    assign clr_req = flag_wr ? bus_wdata : '0;

    p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (act_edge != '0) |=> (($past(act_edge) & ~flag_q) == '0));

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> ((flag_q & $past(bus_wdata & ~act_edge)) == '0));

    p_flag_holds_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(flag_q & ~clr_req) & ~flag_q) == '0));

    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flag_q & ien_q) != '0));

    p_irq_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & ien_q) == '0) |-> !irq);

    p_spi_b_owns_r8: assert property (@(posedge clk) disable iff (rst)
        spi_b_en |-> (pin_out[PORT_W-1:SPI_W] == spi_b_out &&
                      pin_oe[PORT_W-1:SPI_W]  == spi_b_oe));

    p_uart_owns_r9: assert property (@(posedge clk) disable iff (rst)
        (uart_en && !spi_b_en) |-> (pin_out[PORT_W-1:PORT_W-UART_W] == uart_out &&
                                    pin_oe[PORT_W-1:PORT_W-UART_W]  == uart_oe));

    p_spi_a_owns_r10: assert property (@(posedge clk) disable iff (rst)
        spi_a_en |-> (pin_out[SPI_W-1:0] == spi_a_out &&
                      pin_oe[SPI_W-1:0]  == spi_a_oe));
endmodule

bind pinport_ctrl pinport_checker u_pinport_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .flag_q    (regs.flag),
    .ien_q     (regs.ien),
    .act_edge  (act_edge),
    .irq       (irq),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .spi_a_en  (spi_a_en),
    .spi_a_out (spi_a_out),
    .spi_a_oe  (spi_a_oe),
    .spi_b_en  (spi_b_en),
    .spi_b_out (spi_b_out),
    .spi_b_oe  (spi_b_oe),
    .uart_en   (uart_en),
    .uart_out  (uart_out),
    .uart_oe   (uart_oe)
);

// File: tb/test_pinport_ctrl.sv
module test_pinport_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq;
    logic       spi_a_en = 1'b0, spi_b_en = 1'b0, uart_en = 1'b0;
    logic [3:0] spi_a_out = '0, spi_a_oe = '0, spi_b_out = '0, spi_b_oe = '0;
    logic [1:0] uart_out = '0, uart_oe = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pinport_ctrl i_pinport_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
        .spi_a_en(spi_a_en), .spi_a_out(spi_a_out), .spi_a_oe(spi_a_oe),
        .spi_b_en(spi_b_en), .spi_b_out(spi_b_out), .spi_b_oe(spi_b_oe),
        .uart_en(uart_en), .uart_out(uart_out), .uart_oe(uart_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // expected pin drive from the ownership rules (R7-R10)
    function automatic logic [15:0] exp_drive(input logic [7:0] dat, input logic [7:0] dir);
        logic [7:0] o, e;
        for (int i = 0; i < 8; i++) begin
            o[i] = dat[i]; e[i] = dir[i];
            if (i >= 4 && spi_b_en) begin
                o[i] = spi_b_out[i-4]; e[i] = spi_b_oe[i-4];
            end else if (i >= 6 && uart_en) begin
                o[i] = uart_out[i-6]; e[i] = uart_oe[i-6];
            end else if (i < 4 && spi_a_en) begin
                o[i] = spi_a_out[i]; e[i] = spi_a_oe[i];
            end
        end
        return {o, e};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, d, dir, pins;
        logic [15:0] ed;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); check("R1 reg reset", v, 8'h00);
        end
        check("R1 irq reset", {7'd0, irq}, 8'h00);
        check("R1 oe reset", pin_oe, 8'h00);

        // R12 register read-back, random
        for (int k = 0; k < 20; k++) begin
            int a = 1 + int'($urandom_range(2));
            d = 8'($urandom);
            wr(3'(a), d);
            rd(3'(a), v); check("R12 readback", v, d);
        end
        wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        settle();
        wr(3'd4, 8'hFF);

        // R12 unused addresses
        wr(3'd2, 8'h5A);
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd5, v); check("R12 unused read", v, 8'h00);
        rd(3'd7, v); check("R12 unused read", v, 8'h00);
        rd(3'd2, v); check("R12 unused write ignored", v, 8'h5A);
        rd(3'd1, v); check("R12 unused write ignored", v, 8'h00);
        wr(3'd2, 8'h00);

        // R6 mixed read-back, random
        for (int k = 0; k < 15; k++) begin
            d = 8'($urandom); dir = 8'($urandom); pins = 8'($urandom);
            wr(3'd0, d); wr(3'd1, dir);
            pin_in = pins;
            settle();
            rd(3'd0, v); check("R6 data readback", v, (d & dir) | (pins & ~dir));
            // R7 GPIO drive with no peripheral enabled
            check("R7 pin_out", pin_out, d);
            check("R7 pin_oe", pin_oe, dir);
        end

        // R8/R9/R10 ownership chain, random
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            spi_a_en = 1'($urandom); spi_b_en = 1'($urandom); uart_en = 1'($urandom);
            spi_a_out = 4'($urandom); spi_a_oe = 4'($urandom);
            spi_b_out = 4'($urandom); spi_b_oe = 4'($urandom);
            uart_out = 2'($urandom); uart_oe = 2'($urandom);
            #1 ed = exp_drive(d, dir);
            check("R8 R9 R10 pin_out", pin_out, ed[15:8]);
            check("R8 R9 R10 pin_oe", pin_oe, ed[7:0]);
        end
        // directed: serial port overridden by second SPI (R8), then alone (R9)
        @(negedge clk);
        spi_a_en = 0; uart_en = 1; spi_b_en = 1; spi_b_out = 4'hA; spi_b_oe = 4'h6;
        uart_out = 2'b01; uart_oe = 2'b10;
        #1 check("R8 beats serial", pin_out[7:4], 8'h0A);
        @(negedge clk); spi_b_en = 0;
        #1 check("R9 serial pins", {pin_out[7:6], pin_oe[7:6]}, {4'h0, 2'b01, 2'b10});
        check("R9 pins 5..4 GPIO", {6'd0, pin_out[5:4]}, {6'd0, d[5:4]});
        @(negedge clk); uart_en = 0;

        // R2 polarity: pin0 rising-sensitive, pin1 falling-sensitive
        pin_in = 8'h00; settle(); wr(3'd4, 8'hFF);
        wr(3'd2, 8'h01);
        @(negedge clk); pin_in = 8'h03;
        settle();
        rd(3'd4, v); check("R2 rise on pol1, none on pol0", v, 8'h01);
        @(negedge clk); pin_in = 8'h00;
        settle();
        rd(3'd4, v); check("R2 fall on pol0", v, 8'h03);

        // R4 write of zero keeps flags
        wr(3'd4, 8'h00);
        rd(3'd4, v); check("R4 zero write keeps", v, 8'h03);
        // R5 irq follows enable
        check("R5 irq off", {7'd0, irq}, 8'h00);
        wr(3'd3, 8'h02);
        #1 check("R5 irq on", {7'd0, irq}, 8'h01);
        // R3 clear
        wr(3'd4, 8'h02);
        rd(3'd4, v); check("R3 w1c", v, 8'h01);
        #1 check("R5 irq after clear", {7'd0, irq}, 8'h00);

        // R4 same-cycle edge and clear on bit 0 (flag already 1)
        @(negedge clk); pin_in = 8'h01;          // rising edge, detected two edges later
        @(negedge clk);
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = 8'h01; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(3'd4, v); check("R4 edge beats clear", v, 8'h01);
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R3 later clear", v, 8'h00);

        // R11 flags while owned by first SPI
        @(negedge clk); spi_a_en = 1'b1; pin_in = 8'h00;
        settle(); wr(3'd4, 8'hFF);
        @(negedge clk); pin_in = 8'h01;
        settle();
        rd(3'd4, v); check("R11 flag under peripheral", v, 8'h01);
        spi_a_en = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule